// File: doc/BRIEF.md
# Long-Instruction Tracker

This block sits at the dispatch point of a short in-order pipeline. It keeps a record of every multi-cycle ("long") instruction that has been dispatched but has not yet written back. Records are kept in a circular queue. A long instruction that completes dispatch takes the next free slot, and each writeback frees the oldest slot, because long instructions write back in program order.

Every instruction that offers itself for dispatch is compared against all live records. The compare looks for two cases: a source that reads a register still owed by an outstanding long instruction (read-after-write), and a destination that would overwrite such a register (write-after-write). There is no bypass path. A conflict is resolved by holding dispatch ready low until the matching record has retired. Write-after-read needs no check: sources are read from the register file at dispatch, and all writebacks happen in order.

Each accepted long instruction is given a tag, which is its slot pointer including the wrap bit. The writeback side returns that tag when it retires, so that a retire arriving out of order can be flagged. The depth must be a power of two of at least 2.

Top module: `longop_tracker`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, no hazard is reported, and `disp_ready`=1.
- R2: An allocation takes place when `disp_valid`, `disp_ready` and `disp_is_long` are all 1 at a clock edge. In that cycle `disp_tag` shows the slot pointer plus its wrap bit, which is log2(DEPTH)+1 bits wide. Tags start at 0 and increase by 1 per allocation, modulo 2*DEPTH. After an allocation, `empty` becomes 0.
- R3: Once DEPTH records are live, `full`=1. While full, `disp_ready`=0 for a long instruction. A hazard-free instruction that is not long still sees `disp_ready`=1.
- R4: A retire happens when `ret_valid`=1 and the queue is not empty, and it frees the oldest record. When `ret_valid`=1 and the queue is empty, nothing changes: the tag of the next allocation is unchanged and `empty` stays 1.
- R5: `raw_hazard`=1 when a valid source index (`disp_rs1` or `disp_rs2`, each with its own valid flag) equals the destination of a live record. When `raw_hazard`=1, `disp_ready`=0.
- R6: `waw_hazard`=1 when a valid `disp_rd` equals the destination of a live record. When `waw_hazard`=1, `disp_ready`=0.
- R7: Register index 0, or an index whose valid flag is 0, never produces a hazard. This holds on both the probing side and the recorded side.
- R8: The source registers of outstanding records are never compared. A dispatch whose destination equals such a source reports no hazard.
- R9: An allocation and a retire in the same cycle leave the occupancy unchanged.
- R10: Hazards are judged against the records held at the start of the cycle. A retire in the same cycle does not clear the stall. From the next cycle on, the freed record no longer matches.
- R11: `ret_tag_err`=1 exactly when a retire takes place and `ret_tag` differs from the oldest record's tag. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_is_long | input | 1 | The offered instruction is multi-cycle |
| disp_rd_vld | input | 1 | The destination index is meaningful |
| disp_rd | input | RIDX_W | Destination register index |
| disp_rs1_vld | input | 1 | First source index is meaningful |
| disp_rs1 | input | RIDX_W | First source register index |
| disp_rs2_vld | input | 1 | Second source index is meaningful |
| disp_rs2 | input | RIDX_W | Second source register index |
| disp_ready | output | 1 | Dispatch may complete this cycle |
| disp_tag | output | log2(DEPTH)+1 | Tag given to an allocating instruction |
| raw_hazard | output | 1 | A source matches an outstanding destination |
| waw_hazard | output | 1 | The destination matches an outstanding destination |
| ret_valid | input | 1 | A long instruction writes back |
| ret_tag | input | log2(DEPTH)+1 | Tag of the writing-back instruction |
| ret_tag_err | output | 1 | Retire tag differs from the oldest record |
| full | output | 1 | All slots are live |
| empty | output | 1 | No slot is live |

## Verification
A record whose live bit is stale, or whose destination is corrupted, shows up at the ports in the same cycle that a probe touches that register: a hazard appears that should not, or is missing. A read pointer that slips shows up at the next retire as a tag mismatch, and it also shows up as the wrong register staying blocked. A write pointer that slips shows up at once in `disp_tag` and in the cycle on which `full` rises. For this reason the bench follows each allocation and each retire with register probes and flag checks one cycle later.

// File: rtl/longop_pkg.sv
package longop_pkg;
  localparam int unsigned DEPTH_DEF  = 4;
  localparam int unsigned RIDX_W_DEF = 5;

  // slot-index width for a power-of-two depth, never below one bit
  function automatic int unsigned slot_bits(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/longop_ptrs.sv
module longop_ptrs #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SW   = longop_pkg::slot_bits(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic        pop,
  output logic [SW:0] wr_ptr,
  output logic [SW:0] rd_ptr,
  output logic        full,
  output logic        empty
);
  // wrap bit differs and slot bits agree: every slot is occupied
  function automatic logic ptrs_full(input logic [SW:0] w, input logic [SW:0] r);
    return (w[SW] != r[SW]) && (w[SW-1:0] == r[SW-1:0]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign full  = ptrs_full(wr_ptr, rd_ptr);
  assign empty = (wr_ptr == rd_ptr);
endmodule

// File: rtl/longop_store.sv
module longop_store #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned RIDX_W = 5,
  localparam int unsigned SW    = longop_pkg::slot_bits(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [SW-1:0]                 wr_slot,
  input  logic                          in_rd_vld,
  input  logic [RIDX_W-1:0]             in_rd,
  input  logic                          pop,
  input  logic [SW-1:0]                 rd_slot,
  output logic [DEPTH-1:0]              ent_live,
  output logic [DEPTH-1:0]              ent_dst_live,
  output logic [DEPTH-1:0][RIDX_W-1:0]  ent_dst
);
  logic [DEPTH-1:0] dst_ok;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel_wr, sel_rd;
    assign sel_wr = push && (wr_slot == SW'(g));
    assign sel_rd = pop  && (rd_slot == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_live[g] <= 1'b0;
        dst_ok[g]   <= 1'b0;
        ent_dst[g]  <= '0;
      end else if (sel_wr) begin
        ent_live[g] <= 1'b1;
        dst_ok[g]   <= in_rd_vld && (in_rd != '0);
        ent_dst[g]  <= in_rd;
      end else if (sel_rd) begin
        ent_live[g] <= 1'b0;
      end
    end

    assign ent_dst_live[g] = ent_live[g] && dst_ok[g];
  end
endmodule

// File: rtl/longop_hazard.sv
module longop_hazard #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned RIDX_W = 5
) (
  input  logic                          rs1_vld,
  input  logic [RIDX_W-1:0]             rs1,
  input  logic                          rs2_vld,
  input  logic [RIDX_W-1:0]             rs2,
  input  logic                          rd_vld,
  input  logic [RIDX_W-1:0]             rd,
  input  logic [DEPTH-1:0]              ent_dst_live,
  input  logic [DEPTH-1:0][RIDX_W-1:0]  ent_dst,
  output logic [DEPTH-1:0]              raw_hit,
  output logic [DEPTH-1:0]              waw_hit,
  output logic                          raw_any,
  output logic                          waw_any
);
  function automatic logic idx_hit(input logic pv, input logic [RIDX_W-1:0] pi,
                                   input logic ev, input logic [RIDX_W-1:0] ei);
    return pv && ev && (pi != '0) && (pi == ei);
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign raw_hit[g] = idx_hit(rs1_vld, rs1, ent_dst_live[g], ent_dst[g])
                     || idx_hit(rs2_vld, rs2, ent_dst_live[g], ent_dst[g]);
    assign waw_hit[g] = idx_hit(rd_vld, rd, ent_dst_live[g], ent_dst[g]);
  end

  assign raw_any = |raw_hit;
  assign waw_any = |waw_hit;
endmodule

// File: rtl/longop_tracker.sv
module longop_tracker #(
  parameter int unsigned DEPTH  = longop_pkg::DEPTH_DEF,
  parameter int unsigned RIDX_W = longop_pkg::RIDX_W_DEF,
  localparam int unsigned SW    = longop_pkg::slot_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic              disp_is_long,
  input  logic              disp_rd_vld,
  input  logic [RIDX_W-1:0] disp_rd,
  input  logic              disp_rs1_vld,
  input  logic [RIDX_W-1:0] disp_rs1,
  input  logic              disp_rs2_vld,
  input  logic [RIDX_W-1:0] disp_rs2,
  output logic              disp_ready,
  output logic [SW:0]       disp_tag,
  output logic              raw_hazard,
  output logic              waw_hazard,
  input  logic              ret_valid,
  input  logic [SW:0]       ret_tag,
  output logic              ret_tag_err,
  output logic              full,
  output logic              empty
);
  logic [SW:0]                 wr_ptr, rd_ptr;
  logic                        alloc_fire, retire_fire;
  logic [DEPTH-1:0]            ent_live, ent_dst_live;
  logic [DEPTH-1:0][RIDX_W-1:0] ent_dst;
  logic [DEPTH-1:0]            raw_hit, waw_hit;

  assign disp_ready  = !raw_hazard && !waw_hazard && !(disp_is_long && full);
  assign alloc_fire  = disp_valid && disp_ready && disp_is_long;
  assign retire_fire = ret_valid && !empty;
  assign ret_tag_err = retire_fire && (ret_tag != rd_ptr);
  assign disp_tag    = wr_ptr;

  longop_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (alloc_fire),
    .pop    (retire_fire),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .full   (full),
    .empty  (empty)
  );

  longop_store #(.DEPTH(DEPTH), .RIDX_W(RIDX_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .push         (alloc_fire),
    .wr_slot      (wr_ptr[SW-1:0]),
    .in_rd_vld    (disp_rd_vld),
    .in_rd        (disp_rd),
    .pop          (retire_fire),
    .rd_slot      (rd_ptr[SW-1:0]),
    .ent_live     (ent_live),
    .ent_dst_live (ent_dst_live),
    .ent_dst      (ent_dst)
  );

  longop_hazard #(.DEPTH(DEPTH), .RIDX_W(RIDX_W)) u_haz (
    .rs1_vld      (disp_rs1_vld),
    .rs1          (disp_rs1),
    .rs2_vld      (disp_rs2_vld),
    .rs2          (disp_rs2),
    .rd_vld       (disp_rd_vld),
    .rd           (disp_rd),
    .ent_dst_live (ent_dst_live),
    .ent_dst      (ent_dst),
    .raw_hit      (raw_hit),
    .waw_hit      (waw_hit),
    .raw_any      (raw_hazard),
    .waw_any      (waw_hazard)
  );
endmodule

// File: rtl/longop_tracker_chk.sv
module longop_tracker_chk #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned RIDX_W = 5,
  localparam int unsigned SW    = longop_pkg::slot_bits(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_ready,
  input logic             raw_hazard,
  input logic             waw_hazard,
  input logic             full,
  input logic             empty,
  input logic             alloc_fire,
  input logic             retire_fire,
  input logic [SW:0]      wr_ptr,
  input logic [SW:0]      rd_ptr,
  input logic [DEPTH-1:0] ent_live
);
  logic [SW:0] occ;
  assign occ = wr_ptr - rd_ptr;

  // R3: nothing is allocated into a full queue
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_fire);

  // R3: a full queue holds exactly DEPTH live slots
  a_r3_full_all_live: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> ($countones(ent_live) == DEPTH));

  // R1, R7: an empty queue has no live slot and raises no hazard
  a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!raw_hazard && !waw_hazard && (ent_live == '0)));

  // R5: a read-after-write conflict holds dispatch
  a_r5_raw_stall: assert property (@(posedge clk) disable iff (!rst_n)
    raw_hazard |-> !disp_ready);

  // R6: a write-after-write conflict holds dispatch
  a_r6_waw_stall: assert property (@(posedge clk) disable iff (!rst_n)
    waw_hazard |-> !disp_ready);

  // R4: a retire advances the read pointer by exactly one
  a_r4_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire |=> (rd_ptr == (SW+1)'($past(rd_ptr) + 1'b1)));

  // R9: an allocate and a retire together keep the occupancy
  a_r9_swap_keeps_occ: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && retire_fire) |=> (occ == $past(occ)));

  // R2: an allocation leaves the queue non-empty
  a_r2_alloc_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !retire_fire) |=> !empty);
endmodule

bind longop_tracker longop_tracker_chk #(.DEPTH(DEPTH), .RIDX_W(RIDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .disp_ready  (disp_ready),
  .raw_hazard  (raw_hazard),
  .waw_hazard  (waw_hazard),
  .full        (full),
  .empty       (empty),
  .alloc_fire  (alloc_fire),
  .retire_fire (retire_fire),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .ent_live    (ent_live)
);

// File: tb/longop_tracker_tb.sv
`timescale 1ns/1ps
module longop_tracker_tb;
  localparam int unsigned DEPTH  = 4;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned TW     = 3;
  localparam int unsigned NVEC   = 8;
  // vector: rs1v rs1 rs2v rs2 rdv rd exp_raw exp_waw
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1,5'd5, 1'b0,5'd0, 1'b0,5'd0, 1'b1,1'b0},
    {1'b0,5'd0, 1'b1,5'd9, 1'b0,5'd0, 1'b1,1'b0},
    {1'b0,5'd0, 1'b0,5'd0, 1'b1,5'd5, 1'b0,1'b1},
    {1'b1,5'd3, 1'b1,5'd4, 1'b1,5'd6, 1'b0,1'b0},
    {1'b0,5'd5, 1'b0,5'd9, 1'b0,5'd5, 1'b0,1'b0},
    {1'b0,5'd0, 1'b0,5'd0, 1'b1,5'd7, 1'b0,1'b0},
    {1'b1,5'd0, 1'b0,5'd0, 1'b1,5'd0, 1'b0,1'b0},
    {1'b1,5'd9, 1'b0,5'd0, 1'b1,5'd5, 1'b1,1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid, disp_is_long, disp_rd_vld, disp_rs1_vld, disp_rs2_vld;
  logic [RIDX_W-1:0] disp_rd, disp_rs1, disp_rs2;
  logic disp_ready, raw_hazard, waw_hazard, ret_valid, ret_tag_err, full, empty;
  logic [TW-1:0] disp_tag, ret_tag;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  longop_tracker #(.DEPTH(DEPTH), .RIDX_W(RIDX_W)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_is_long = 0; disp_rd_vld = 0; disp_rd = '0;
    disp_rs1_vld = 0; disp_rs1 = '0; disp_rs2_vld = 0; disp_rs2 = '0;
    ret_valid = 0; ret_tag = '0;
  endtask

  task automatic probe(input logic s1v, input logic [4:0] s1, input logic s2v, input logic [4:0] s2,
                       input logic dv, input logic [4:0] d, input logic lng);
    disp_valid = 1; disp_is_long = lng;
    disp_rs1_vld = s1v; disp_rs1 = s1; disp_rs2_vld = s2v; disp_rs2 = s2;
    disp_rd_vld = dv; disp_rd = d;
  endtask

  // at a negedge: offer a long op, check tag, commit at the next edge
  task automatic alloc(input logic [4:0] d, input logic [4:0] s1, input int exp_tag);
    probe(1, s1, 0, 0, 1, d, 1);
    #1;
    chk("R2 tag", disp_tag, exp_tag);
    @(negedge clk); idle();
  endtask

  task automatic retire(input int tag, input logic exp_err, input string req);
    ret_valid = 1; ret_tag = TW'(tag);
    #1;
    chk(req, ret_tag_err, exp_err);
    @(negedge clk); idle();
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 ready", disp_ready, 1); chk("R1 raw", raw_hazard, 0);
    @(negedge clk);

    alloc(5'd5, 5'd7, 0);
    chk("R2 nonempty", empty, 0);
    alloc(5'd9, 5'd0, 1);
    alloc(5'd0, 5'd0, 2);

    // R5 R6 R7 R8: vector table against records rd=5, rd=9, rd=0
    for (int i = 0; i < NVEC; i++) begin
      probe(VEC[i][19], VEC[i][18:14], VEC[i][13], VEC[i][12:8], VEC[i][7], VEC[i][6:2], 0);
      #1;
      chk("R5 raw vector", raw_hazard, VEC[i][1]);
      chk("R6 waw vector", waw_hazard, VEC[i][0]);
      chk("R7 ready vector", disp_ready, !(VEC[i][1] || VEC[i][0]));
      @(negedge clk); idle();
    end

    alloc(5'd12, 5'd0, 3);
    chk("R3 full", full, 1);
    probe(1, 5'd3, 0, 0, 1, 5'd4, 1); #1;
    chk("R3 long blocked", disp_ready, 0);
    disp_is_long = 0; #0.5;
    chk("R3 short passes", disp_ready, 1);
    @(negedge clk); idle();
    chk("R3 still full", full, 1);

    retire(1, 1'b1, "R11 wrong tag");
    chk("R4 not full", full, 0);
    probe(0, 0, 0, 0, 1, 5'd5, 0); #1;
    chk("R4 oldest freed", waw_hazard, 0);
    disp_rd = 5'd9; #0.5;
    chk("R4 next kept", waw_hazard, 1);
    @(negedge clk); idle();
    retire(1, 1'b0, "R11 right tag");

    // R9: allocate and retire together
    probe(0, 0, 0, 0, 1, 5'd20, 1); ret_valid = 1; ret_tag = 3'd2; #1;
    chk("R9 tag wrap", disp_tag, 4);
    @(negedge clk); idle();
    chk("R9 not full", full, 0); chk("R9 not empty", empty, 0);
    probe(0, 0, 0, 0, 1, 5'd20, 0); #1;
    chk("R9 new live", waw_hazard, 1);
    disp_rd = 5'd12; #0.5;
    chk("R9 old live", waw_hazard, 1);
    @(negedge clk); idle();

    retire(3, 1'b0, "R11 drain a");
    retire(4, 1'b0, "R11 drain b");
    chk("R4 drained", empty, 1);
    retire(5, 1'b0, "R4 empty retire no err");
    chk("R4 empty kept", empty, 1);

    alloc(5'd8, 5'd0, 5);
    // R10: retire in same cycle does not clear the stall
    probe(1, 5'd8, 0, 0, 0, 0, 0); ret_valid = 1; ret_tag = 3'd5; #1;
    chk("R10 raw same cycle", raw_hazard, 1);
    chk("R10 ready same cycle", disp_ready, 0);
    @(negedge clk);
    ret_valid = 0; #1;
    chk("R10 raw cleared", raw_hazard, 0);
    chk("R10 ready back", disp_ready, 1);
    chk("R10 empty", empty, 1);
    @(negedge clk); idle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule